// File: doc/BRIEF.md
# I2C Status Flag Controller

This block holds the first status register of an I2C peripheral and applies the rules by which each of its flags sets and clears. The bus engine reports what happens on the wire through single-cycle event strobes: byte finished, own address or general call matched, start generated, start or stop seen on the bus, missing acknowledge, arbitration lost, bus error, first byte of a 10-bit address sent, and an address byte sent as master. The register interface sends single-cycle access strobes for reads of either status register, reads of the received-data register and writes of the transmit-data register.

Several flags clear only after a specific series of accesses. Software must read status register 1 and then touch the data register before the byte-finished flag drops. A byte-finished event or an address match makes the block hold SCL low and, when interrupts are enabled, raise a request. A summary event bit collects every pending condition. Clearing the peripheral enable resets all flags except the bus-busy bit, which keeps following the bus. All outputs are registered, so a strobe sampled at a clock edge shows its effect from that edge on.

Top module: `i2c_flag_ctrl`

## Requirements
- R1: After reset all eight bits of `stat1`, `irq` and `scl_hold` are 0. The bit order of `stat1`, from bit 7 down to bit 0, is: event, 10-bit header, transmitter, bus busy, byte finished, address matched, master, start sent.
- R2: Bus busy (bit 4) sets on `ev_start_det` and clears on `ev_stop_det`, with the clear winning. It tracks the bus even while `enable` is 0.
- R3: While `enable` is 0, every bit of `stat1` except bit 4 is 0 from the next edge on. Events are ignored during that time.
- R4: Address matched (bit 2) sets on `ev_addr_match` or `ev_gen_call`. It clears on `rd_stat1`, and a set in the same cycle wins.
- R5: On `ev_byte_done`, byte finished (bit 3) sets and the transmitter bit (bit 5) takes the value of `ev_byte_tx`. Bit 5 is never 1 while bit 3 is 0.
- R6: Byte finished clears only when an `rd_stat1` issued while it was 1 is followed by the matching data access: `wr_dout` if bit 5 is 1, `rd_din` otherwise. Bit 5 clears along with it. The other data access leaves both bits unchanged.
- R7: An `ev_byte_done` that arrives after the arming status read and before the data access (or together with the access) cancels the arming. The flag stays 1 and a new status read is needed.
- R8: `ev_stop_det` or `ev_arb_lost` clears the transmitter bit unless `ev_byte_done` comes in the same cycle.
- R9: `ev_start_gen` sets master (bit 1) and start sent (bit 0). Master clears on `ev_stop_det` or `ev_arb_lost`, and that clear wins. Start sent clears when an `rd_stat1` issued while it was 1 is followed by `wr_dout`.
- R10: `ev_hdr10_sent` sets the 10-bit header bit (bit 6). It clears when an `rd_stat2` issued while it was 1 is followed by `wr_dout`. A `wr_dout` without that read has no effect.
- R11: The event bit (bit 7) is 1 whenever bit 3, bit 2 or bit 0 is 1, or an error or address event is pending. The pending condition is set by `ev_nack`, `ev_arb_lost`, `ev_bus_err`, `ev_addr_sent`, or `ev_stop_det` while master is 0. It is cleared by `rd_stat2`, and a set in the same cycle wins.
- R12: `scl_hold` is 1 exactly while bit 3 or bit 2 is 1. `irq` is that value ANDed with `irq_enable`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Peripheral enable |
| irq_enable | input | 1 | Interrupt enable |
| ev_byte_done | input | 1 | A byte was received or transmitted |
| ev_byte_tx | input | 1 | Direction of that byte, 1 = transmitted |
| ev_addr_match | input | 1 | Own slave address matched |
| ev_gen_call | input | 1 | General call recognised |
| ev_start_gen | input | 1 | Start generated as master |
| ev_start_det | input | 1 | Start condition seen on the bus |
| ev_stop_det | input | 1 | Stop condition seen on the bus |
| ev_nack | input | 1 | No acknowledge after a sent byte |
| ev_arb_lost | input | 1 | Arbitration lost |
| ev_bus_err | input | 1 | Misplaced start or stop |
| ev_hdr10_sent | input | 1 | First byte of a 10-bit address sent |
| ev_addr_sent | input | 1 | Address byte sent as master |
| rd_stat1 | input | 1 | Status register 1 read strobe |
| rd_stat2 | input | 1 | Status register 2 read strobe |
| rd_din | input | 1 | Received-data register read strobe |
| wr_dout | input | 1 | Transmit-data register write strobe |
| stat1 | output | 8 | Status register 1 contents |
| irq | output | 1 | Interrupt request |
| scl_hold | output | 1 | Hold SCL low |

## Verification
The key collision is a new byte-finished event in the same cycle as, or just before, the data access that would complete the clear sequence. The event must win, and the arming must be cancelled. Directed sequences arm the clear with a status read, then place the event either one cycle before the access or in the same cycle as it, and then confirm that bit 3 is still 1 and that one more status read plus access clears it. Random stimulus with dense strobes also lands stop detection on top of byte completion and address matches on top of status reads. A bench model built from the requirements judges every cycle field by field.

// File: rtl/i2c_flag_ctrl.sv
module i2c_flag_ctrl (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       enable,
  input  logic       irq_enable,
  input  logic       ev_byte_done,
  input  logic       ev_byte_tx,
  input  logic       ev_addr_match,
  input  logic       ev_gen_call,
  input  logic       ev_start_gen,
  input  logic       ev_start_det,
  input  logic       ev_stop_det,
  input  logic       ev_nack,
  input  logic       ev_arb_lost,
  input  logic       ev_bus_err,
  input  logic       ev_hdr10_sent,
  input  logic       ev_addr_sent,
  input  logic       rd_stat1,
  input  logic       rd_stat2,
  input  logic       rd_din,
  input  logic       wr_dout,
  output logic [7:0] stat1,
  output logic       irq,
  output logic       scl_hold
);

  logic busy, master, start_sent, start_arm;
  logic matched, done, xmit, done_arm;
  logic hdr10, hdr10_arm, pending;

  wire ends_mastership = ev_stop_det | ev_arb_lost;
  wire done_access     = xmit ? wr_dout : rd_din;
  wire pend_set        = ev_nack | ev_arb_lost | ev_bus_err | ev_addr_sent
                       | (ev_stop_det & ~master);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)           busy <= 1'b0;
    else if (ev_stop_det) busy <= 1'b0;
    else if (ev_start_det) busy <= 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n || !enable) master <= 1'b0;
    else                   master <= (master | ev_start_gen) & ~ends_mastership;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n || !enable) begin
      start_sent <= 1'b0;
      start_arm  <= 1'b0;
    end else if (ev_start_gen) begin
      start_sent <= 1'b1;
      start_arm  <= 1'b0;
    end else if (start_arm && wr_dout) begin
      start_sent <= 1'b0;
      start_arm  <= 1'b0;
    end else if (rd_stat1 && start_sent) begin
      start_arm  <= 1'b1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n || !enable)             matched <= 1'b0;
    else if (ev_addr_match || ev_gen_call) matched <= 1'b1;
    else if (rd_stat1)                 matched <= 1'b0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n || !enable) begin
      done     <= 1'b0;
      xmit     <= 1'b0;
      done_arm <= 1'b0;
    end else if (ev_byte_done) begin
      done     <= 1'b1;
      xmit     <= ev_byte_tx;
      done_arm <= 1'b0;
    end else if (done_arm && done_access) begin
      done     <= 1'b0;
      xmit     <= 1'b0;
      done_arm <= 1'b0;
    end else begin
      if (rd_stat1 && done) done_arm <= 1'b1;
      if (ends_mastership)  xmit     <= 1'b0;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n || !enable) begin
      hdr10     <= 1'b0;
      hdr10_arm <= 1'b0;
    end else if (ev_hdr10_sent) begin
      hdr10     <= 1'b1;
      hdr10_arm <= 1'b0;
    end else if (hdr10_arm && wr_dout) begin
      hdr10     <= 1'b0;
      hdr10_arm <= 1'b0;
    end else if (rd_stat2 && hdr10) begin
      hdr10_arm <= 1'b1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n || !enable) pending <= 1'b0;
    else if (pend_set)     pending <= 1'b1;
    else if (rd_stat2)     pending <= 1'b0;

  assign scl_hold = done | matched;
  assign irq      = scl_hold & irq_enable;
  assign stat1    = {done | matched | start_sent | pending,
                     hdr10, xmit, busy, done, matched, master, start_sent};

  AST_BUSY_FOLLOWS_START: assert property (@(posedge clk) disable iff (!rst_n)
    ev_start_det && !ev_stop_det |=> stat1[4]); // R2
  AST_OFF_CLEARS_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (stat1 & 8'hEF) == 8'h00); // R3
  AST_MATCH_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    enable && (ev_addr_match || ev_gen_call) |=> stat1[2]); // R4
  AST_XMIT_NEEDS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    stat1[5] |-> stat1[3]); // R5
  AST_DONE_NEEDS_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    enable && stat1[3] && !rd_din && !wr_dout |=> stat1[3]); // R6
  AST_STOP_ENDS_MASTER: assert property (@(posedge clk) disable iff (!rst_n)
    ev_stop_det |=> !stat1[1]); // R9
  AST_IRQ_NEEDS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> scl_hold); // R12

endmodule

// File: tb/test_i2c_flag_ctrl.sv
`timescale 1ns/1ps
module test_i2c_flag_ctrl;
  logic clk = 1'b0, rst_n = 1'b0;
  logic enable = 1'b1, irq_enable = 1'b0;
  logic ev_byte_done = 0, ev_byte_tx = 0, ev_addr_match = 0, ev_gen_call = 0;
  logic ev_start_gen = 0, ev_start_det = 0, ev_stop_det = 0, ev_nack = 0;
  logic ev_arb_lost = 0, ev_bus_err = 0, ev_hdr10_sent = 0, ev_addr_sent = 0;
  logic rd_stat1 = 0, rd_stat2 = 0, rd_din = 0, wr_dout = 0;
  logic [7:0] stat1;
  logic irq, scl_hold;

  int checks = 0, failures = 0;

  logic m_busy, m_mst, m_sb, m_sb_arm, m_adr, m_btf, m_tra, m_btf_arm;
  logic m_h10, m_h10_arm, m_pend;

  always #2.5 clk = ~clk;

  i2c_flag_ctrl i_i2c_flag_ctrl (
    .clk(clk), .rst_n(rst_n), .enable(enable), .irq_enable(irq_enable),
    .ev_byte_done(ev_byte_done), .ev_byte_tx(ev_byte_tx),
    .ev_addr_match(ev_addr_match), .ev_gen_call(ev_gen_call),
    .ev_start_gen(ev_start_gen), .ev_start_det(ev_start_det),
    .ev_stop_det(ev_stop_det), .ev_nack(ev_nack), .ev_arb_lost(ev_arb_lost),
    .ev_bus_err(ev_bus_err), .ev_hdr10_sent(ev_hdr10_sent),
    .ev_addr_sent(ev_addr_sent), .rd_stat1(rd_stat1), .rd_stat2(rd_stat2),
    .rd_din(rd_din), .wr_dout(wr_dout),
    .stat1(stat1), .irq(irq), .scl_hold(scl_hold));

  function automatic logic [7:0] exp_stat1();
    return {m_btf | m_adr | m_sb | m_pend, m_h10, m_tra, m_busy,
            m_btf, m_adr, m_mst, m_sb};
  endfunction

  task automatic chk(string req, string what, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic model_reset();
    {m_busy, m_mst, m_sb, m_sb_arm, m_adr, m_btf, m_tra, m_btf_arm} = '0;
    {m_h10, m_h10_arm, m_pend} = '0;
  endtask

  task automatic model_step();
    logic mst_old;
    mst_old = m_mst;
    if (ev_stop_det) m_busy = 0; else if (ev_start_det) m_busy = 1;
    if (!enable) begin
      {m_mst, m_sb, m_sb_arm, m_adr, m_btf, m_tra, m_btf_arm} = '0;
      {m_h10, m_h10_arm, m_pend} = '0;
      return;
    end
    if (ev_stop_det || ev_arb_lost) m_mst = 0; else if (ev_start_gen) m_mst = 1;
    if (ev_start_gen) begin m_sb = 1; m_sb_arm = 0; end
    else if (m_sb_arm && wr_dout) begin m_sb = 0; m_sb_arm = 0; end
    else if (rd_stat1 && m_sb) m_sb_arm = 1;
    if (ev_addr_match || ev_gen_call) m_adr = 1; else if (rd_stat1) m_adr = 0;
    if (ev_byte_done) begin m_btf = 1; m_tra = ev_byte_tx; m_btf_arm = 0; end
    else if (m_btf_arm && (m_tra ? wr_dout : rd_din)) begin
      m_btf = 0; m_tra = 0; m_btf_arm = 0;
    end else begin
      if (rd_stat1 && m_btf) m_btf_arm = 1;
      if (ev_stop_det || ev_arb_lost) m_tra = 0;
    end
    if (ev_hdr10_sent) begin m_h10 = 1; m_h10_arm = 0; end
    else if (m_h10_arm && wr_dout) begin m_h10 = 0; m_h10_arm = 0; end
    else if (rd_stat2 && m_h10) m_h10_arm = 1;
    if (ev_nack || ev_arb_lost || ev_bus_err || ev_addr_sent || (ev_stop_det && !mst_old))
      m_pend = 1;
    else if (rd_stat2) m_pend = 0;
  endtask

  task automatic clear_strobes();
    {ev_byte_done, ev_byte_tx, ev_addr_match, ev_gen_call, ev_start_gen} = '0;
    {ev_start_det, ev_stop_det, ev_nack, ev_arb_lost, ev_bus_err} = '0;
    {ev_hdr10_sent, ev_addr_sent, rd_stat1, rd_stat2, rd_din, wr_dout} = '0;
  endtask

  task automatic tick();
    logic [7:0] e;
    @(posedge clk);
    #1;
    model_step();
    e = exp_stat1();
    chk("R2", "busy", {7'd0, stat1[4]}, {7'd0, e[4]});
    chk("R4", "addr_matched", {7'd0, stat1[2]}, {7'd0, e[2]});
    chk("R6", "byte_done", {7'd0, stat1[3]}, {7'd0, e[3]});
    chk("R5", "transmitter", {7'd0, stat1[5]}, {7'd0, e[5]});
    chk("R9", "master/start", {6'd0, stat1[1:0]}, {6'd0, e[1:0]});
    chk("R10", "hdr10", {7'd0, stat1[6]}, {7'd0, e[6]});
    chk("R11", "event", {7'd0, stat1[7]}, {7'd0, e[7]});
    chk("R12", "scl_hold", {7'd0, scl_hold}, {7'd0, e[3] | e[2]});
    chk("R12", "irq", {7'd0, irq}, {7'd0, (e[3] | e[2]) & irq_enable});
    clear_strobes();
  endtask

  initial begin
    #(5.0 * 150000);
    failures++;
    checks++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    model_reset();
    repeat (3) @(posedge clk);
    #1;
    chk("R1", "reset stat1", stat1, 8'h00);
    chk("R1", "reset outputs", {6'd0, irq, scl_hold}, 8'h00);
    rst_n = 1'b1;
    tick();
    chk("R1", "idle stat1", stat1, 8'h00);

    ev_byte_done = 1; ev_byte_tx = 1; tick();
    chk("R5", "tx byte sets bits 7,5,3", stat1, 8'hA8);
    rd_din = 1; tick();
    chk("R6", "wrong access keeps flag", stat1, 8'hA8);
    rd_stat1 = 1; tick();
    wr_dout = 1; tick();
    chk("R6", "read then write clears", stat1, 8'h00);

    ev_byte_done = 1; tick();
    rd_stat1 = 1; tick();
    ev_byte_done = 1; tick();
    rd_din = 1; tick();
    chk("R7", "event between read and access", stat1, 8'h88);
    rd_stat1 = 1; tick();
    ev_byte_done = 1; rd_din = 1; tick();
    chk("R7", "event with access", stat1, 8'h88);
    rd_stat1 = 1; tick();
    rd_din = 1; tick();
    chk("R6", "rx clear", stat1, 8'h00);

    ev_byte_done = 1; ev_byte_tx = 1; tick();
    ev_stop_det = 1; tick();
    chk("R8", "stop clears transmitter", stat1 & 8'h28, 8'h08);
    rd_stat1 = 1; tick();
    rd_din = 1; tick();
    rd_stat2 = 1; tick();
    chk("R11", "pending cleared by status2", stat1, 8'h00);

    ev_hdr10_sent = 1; tick();
    wr_dout = 1; tick();
    chk("R10", "write alone keeps hdr10", stat1[6], 1'b1);
    rd_stat2 = 1; tick();
    wr_dout = 1; tick();
    chk("R10", "status2 then write clears", stat1[6], 1'b0);

    ev_start_gen = 1; ev_start_det = 1; tick();
    chk("R9", "start sets master and start bits", stat1, 8'h93);
    ev_arb_lost = 1; tick();
    chk("R9", "arbitration loss drops master", stat1[1], 1'b0);
    rd_stat1 = 1; rd_stat2 = 1; tick();
    wr_dout = 1; tick();
    chk("R9", "start bit cleared", stat1, 8'h10);

    ev_nack = 1; tick();
    chk("R11", "nack raises event", stat1[7], 1'b1);
    rd_stat2 = 1; tick();
    chk("R11", "status2 clears event", stat1[7], 1'b0);

    irq_enable = 1; ev_addr_match = 1; tick();
    chk("R12", "irq on match", {6'd0, irq, scl_hold}, 8'h03);
    enable = 0; ev_stop_det = 1; ev_addr_match = 1; tick();
    chk("R3", "disable clears all but busy", stat1, 8'h00);
    ev_start_det = 1; ev_byte_done = 1; tick();
    chk("R2", "busy tracks while disabled", stat1, 8'h10);
    enable = 1; ev_stop_det = 1; tick();

    for (int n = 0; n < 20000; n++) begin
      enable       = ($urandom % 32) != 0;
      irq_enable   = ($urandom % 4) != 0;
      ev_byte_done = ($urandom % 8) == 0;
      ev_byte_tx   = $urandom % 2;
      ev_addr_match = ($urandom % 12) == 0;
      ev_gen_call  = ($urandom % 24) == 0;
      ev_start_gen = ($urandom % 16) == 0;
      ev_start_det = ($urandom % 12) == 0;
      ev_stop_det  = ($urandom % 14) == 0;
      ev_nack      = ($urandom % 20) == 0;
      ev_arb_lost  = ($urandom % 24) == 0;
      ev_bus_err   = ($urandom % 30) == 0;
      ev_hdr10_sent = ($urandom % 20) == 0;
      ev_addr_sent = ($urandom % 20) == 0;
      rd_stat1     = ($urandom % 4) == 0;
      rd_stat2     = ($urandom % 5) == 0;
      rd_din       = ($urandom % 4) == 0;
      wr_dout      = ($urandom % 4) == 0;
      tick();
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule